// File: doc/BRIEF.md
# Indirect Register Access Window

This block is an APB slave that reaches two internal register spaces through small address/data windows, not through a flat memory map. Each space has three registers of its own: an index register, a data port and a control register. One space is 32 bits wide (the "top" space). The other is 8 bits wide (the "controller" space). Each space is served by a simple register-file port with a combinational read path and a single-cycle write strobe.

The windows follow two access rules that software has to obey.

- An index takes effect only when the same value has been written to the index register twice in a row.
- Data reads are prefetched. Each read of the data port returns what the previous read fetched, then fetches again from the committed index. The first read after a new index is therefore stale, and the second read is correct.

A data write needs only one access once an index has been committed. Bit 15 of each control register turns on fail-on-error. With fail-on-error set, a data access made with no committed index completes with PSLVERR high.

Top module: `iw_apb_window`

## Requirements
- R1: Offsets 0x00, 0x04 and 0x08 select the index, data and control registers of the 32-bit space. Offsets 0x10, 0x14 and 0x18 select the same three registers of the 8-bit space. PREADY is high in every access phase, so every access completes in one cycle.
- R2: Only bits [15:0] of an index write are kept. A value becomes the committed index, driven on the space's address output and read back in bits [15:0] of the index register, only on the second of two consecutive index writes carrying the same value.
- R3: If the second index write carries a different value, that value becomes the new pending value and no commit occurs. Any other access to the same window discards a pending value.
- R4: A data-port read returns the current prefetch content (zero after reset). When an index is committed, the same access also reads the internal register at that index into the prefetch register. The first read after a commit therefore returns stale data, and the second returns the register's value.
- R5: With an index committed, a single data-port write produces exactly one write strobe to the internal register at the committed index, carrying the written data.
- R6: The 8-bit space takes only bits [7:0] of written data, and reads of its data port return zero in bits [31:8]. The 32-bit space carries all 32 bits.
- R7: Bit 15 of a control register holds the fail-on-error enable and reads back in bit 15. All other control bits read as zero.
- R8: A data access with no committed index is dropped: no write strobe and no internal read. PSLVERR is high for that access if and only if fail-on-error is set on that window. PSLVERR stays low for every legal access.
- R9: Any other offset reads as zero. It asserts PSLVERR only when fail-on-error is set on both windows.
- R10: Reset clears the committed and pending indexes, both prefetch registers and both control registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error response |
| top_wr | output | 1 | 32-bit space write strobe |
| top_addr | output | 16 | 32-bit space committed index |
| top_wdata | output | 32 | 32-bit space write data |
| top_rdata | input | 32 | 32-bit space read data |
| ctl_wr | output | 1 | 8-bit space write strobe |
| ctl_addr | output | 16 | 8-bit space committed index |
| ctl_wdata | output | 8 | 8-bit space write data |
| ctl_rdata | input | 8 | 8-bit space read data |

## Verification
A single data-port read both returns the old prefetch content and loads new content, in the same cycle. The bench provokes this by changing the internal register between reads: it commits a new index and writes a fresh value there, then reads twice. The first read must show the value fetched under the previous index, and the second must show the new value. This is swept over eight indexes in both spaces, and the bench's expected prefetch is carried forward from one index to the next.

// File: rtl/iw_pkg.sv
package iw_pkg;

    localparam int BUS_W   = 32;
    localparam int IDX_W   = 16;
    localparam int FE_BIT  = 15;

    typedef enum logic [1:0] {
        SEL_IDX  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef struct packed {
        logic  hit;
        logic  win;
        wsel_e sel;
    } dec_t;

    typedef struct packed {
        logic             pend_v;
        logic [IDX_W-1:0] pend_a;
        logic             com_v;
        logic [IDX_W-1:0] com_a;
        logic             fe;
    } win_state_t;

    function automatic dec_t decode_offset(input logic [BUS_W-1:0] off);
        dec_t d;
        d.hit = 1'b0;
        d.win = off[4];
        d.sel = SEL_NONE;
        if (off[BUS_W-1:5] == '0 && off[1:0] == 2'b00 && off[3:2] != 2'd3) begin
            d.hit = 1'b1;
            d.sel = wsel_e'(off[3:2]);
        end
        return d;
    endfunction

endpackage

// File: rtl/iw_decode.sv
module iw_decode
    import iw_pkg::*;
#(
    parameter int PADDR_W = 8
) (
    input  logic               psel,
    input  logic               penable,
    input  logic [PADDR_W-1:0] paddr,
    output logic               acc_top,
    output logic               acc_ctl,
    output logic               acc_undef,
    output wsel_e              sel
);
    dec_t d;

    always_comb begin
        d         = decode_offset(BUS_W'(paddr));
        sel       = d.sel;
        acc_top   = psel && penable && d.hit && !d.win;
        acc_ctl   = psel && penable && d.hit &&  d.win;
        acc_undef = psel && penable && !d.hit;
    end
endmodule

// File: rtl/iw_window.sv
module iw_window
    import iw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  wsel_e            sel,
    input  logic             pwrite,
    input  logic [BUS_W-1:0] pwdata,
    output logic [BUS_W-1:0] rd_val,
    output logic             err,
    output logic             fe,
    output logic             rf_wr,
    output logic             rf_rd,
    output logic [IDX_W-1:0] rf_addr,
    output logic [DW-1:0]    rf_wdata,
    input  logic [DW-1:0]    rf_rdata
);
    win_state_t       st;
    logic [DW-1:0]    pf;
    logic [IDX_W-1:0] wa;
    logic             idx_wr;

    assign wa       = pwdata[IDX_W-1:0];
    assign idx_wr   = acc && sel == SEL_IDX && pwrite;
    assign rf_addr  = st.com_a;
    assign rf_wdata = pwdata[DW-1:0];
    assign rf_wr    = acc && sel == SEL_DATA &&  pwrite && st.com_v;
    assign rf_rd    = acc && sel == SEL_DATA && !pwrite && st.com_v;
    assign err      = acc && sel == SEL_DATA && !st.com_v && st.fe;
    assign fe       = st.fe;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
            pf <= '0;
        end else begin
            if (acc) begin
                if (idx_wr) begin
                    if (st.pend_v && st.pend_a == wa) begin
                        st.com_v  <= 1'b1;
                        st.com_a  <= wa;
                        st.pend_v <= 1'b0;
                    end else begin
                        st.pend_v <= 1'b1;
                        st.pend_a <= wa;
                    end
                end else begin
                    st.pend_v <= 1'b0;
                end
                if (sel == SEL_CTRL && pwrite)
                    st.fe <= pwdata[FE_BIT];
            end
            if (rf_rd)
                pf <= rf_rdata;
        end
    end

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_IDX:  rd_val[IDX_W-1:0] = st.com_a;
            SEL_DATA: rd_val[DW-1:0]    = pf;
            SEL_CTRL: rd_val[FE_BIT]    = st.fe;
            default:  rd_val            = '0;
        endcase
    end

    AST_COMMIT_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && st.pend_v && st.pend_a == wa) |=> (st.com_v && rf_addr == $past(wa))); // R2
    AST_NO_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && !st.pend_v) |=> $stable(rf_addr)); // R2
    AST_PEND_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (acc && !idx_wr) |=> !st.pend_v); // R3
    AST_PREFETCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        rf_rd |=> (pf == $past(rf_rdata))); // R4
    AST_ERR_DROPS: assert property (@(posedge clk) disable iff (rst)
        err |-> (!rf_wr && !rf_rd)); // R8
    AST_FE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(acc && sel == SEL_CTRL && pwrite) |=> $stable(fe)); // R7
endmodule

// File: rtl/iw_resp.sv
module iw_resp
    import iw_pkg::*;
(
    input  logic             acc_top,
    input  logic             acc_ctl,
    input  logic             acc_undef,
    input  logic             pwrite,
    input  logic [BUS_W-1:0] rd_top,
    input  logic [BUS_W-1:0] rd_ctl,
    input  logic             err_top,
    input  logic             err_ctl,
    input  logic             fe_top,
    input  logic             fe_ctl,
    output logic [BUS_W-1:0] prdata,
    output logic             pslverr
);
    always_comb begin
        prdata = '0;
        if (!pwrite) begin
            if (acc_top)      prdata = rd_top;
            else if (acc_ctl) prdata = rd_ctl;
        end
        pslverr = (acc_top && err_top) || (acc_ctl && err_ctl)
               || (acc_undef && fe_top && fe_ctl);
    end
endmodule

// File: rtl/iw_apb_window.sv
module iw_apb_window
    import iw_pkg::*;
#(
    parameter int PADDR_W = 8,
    parameter int TOP_DW  = 32,
    parameter int CTL_DW  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    output logic               top_wr,
    output logic [15:0]        top_addr,
    output logic [TOP_DW-1:0]  top_wdata,
    input  logic [TOP_DW-1:0]  top_rdata,
    output logic               ctl_wr,
    output logic [15:0]        ctl_addr,
    output logic [CTL_DW-1:0]  ctl_wdata,
    input  logic [CTL_DW-1:0]  ctl_rdata
);
    logic             acc_top, acc_ctl, acc_undef;
    wsel_e            sel;
    logic [BUS_W-1:0] rd_top, rd_ctl;
    logic             err_top, err_ctl, fe_top, fe_ctl;
    logic             top_rd, ctl_rd;

    iw_decode #(.PADDR_W(PADDR_W)) u_dec (
        .psel(psel), .penable(penable), .paddr(paddr),
        .acc_top(acc_top), .acc_ctl(acc_ctl), .acc_undef(acc_undef), .sel(sel)
    );

    iw_window #(.DW(TOP_DW)) u_win_top (
        .clk(clk), .rst(rst), .acc(acc_top), .sel(sel), .pwrite(pwrite),
        .pwdata(pwdata), .rd_val(rd_top), .err(err_top), .fe(fe_top),
        .rf_wr(top_wr), .rf_rd(top_rd), .rf_addr(top_addr),
        .rf_wdata(top_wdata), .rf_rdata(top_rdata)
    );

    iw_window #(.DW(CTL_DW)) u_win_ctl (
        .clk(clk), .rst(rst), .acc(acc_ctl), .sel(sel), .pwrite(pwrite),
        .pwdata(pwdata), .rd_val(rd_ctl), .err(err_ctl), .fe(fe_ctl),
        .rf_wr(ctl_wr), .rf_rd(ctl_rd), .rf_addr(ctl_addr),
        .rf_wdata(ctl_wdata), .rf_rdata(ctl_rdata)
    );

    iw_resp u_resp (
        .acc_top(acc_top), .acc_ctl(acc_ctl), .acc_undef(acc_undef),
        .pwrite(pwrite), .rd_top(rd_top), .rd_ctl(rd_ctl),
        .err_top(err_top), .err_ctl(err_ctl), .fe_top(fe_top), .fe_ctl(fe_ctl),
        .prdata(prdata), .pslverr(pslverr)
    );

    assign pready = psel && penable;

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_undef |-> (prdata == '0)); // R9
    AST_ERR_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> pready); // R8
    AST_ONE_SPACE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({top_wr, ctl_wr, top_rd, ctl_rd})); // R1
endmodule

// File: tb/test_iw_apb_window.sv
`timescale 1ns/1ps
module test_iw_apb_window;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        top_wr, ctl_wr;
    logic [15:0] top_addr, ctl_addr;
    logic [31:0] top_wdata, top_rdata;
    logic [7:0]  ctl_wdata, ctl_rdata;

    logic [31:0] tmem [16];
    logic [7:0]  cmem [16];
    int          top_wr_cnt, ctl_wr_cnt;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    iw_apb_window i_iw_apb_window (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .top_wr(top_wr), .top_addr(top_addr),
        .top_wdata(top_wdata), .top_rdata(top_rdata), .ctl_wr(ctl_wr),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    assign top_rdata = tmem[top_addr[3:0]];
    assign ctl_rdata = cmem[ctl_addr[3:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) begin
                tmem[i] <= 32'h1000_0000 + 32'(i);
                cmem[i] <= 8'(8'h40 + i);
            end
            top_wr_cnt <= 0;
            ctl_wr_cnt <= 0;
        end else begin
            if (top_wr) begin
                tmem[top_addr[3:0]] <= top_wdata;
                top_wr_cnt <= top_wr_cnt + 1;
            end
            if (ctl_wr) begin
                cmem[ctl_addr[3:0]] <= ctl_wdata;
                ctl_wr_cnt <= ctl_wr_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [31:0] r_rd;
    logic        r_err, r_rdy;

    task automatic apb(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        r_rd = prdata; r_err = pslverr; r_rdy = pready;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    logic [31:0] exp_pf [2];
    logic [31:0] v, m;
    int          cnt0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        apb(1'b0, 8'h00, 0); chk("R10 top index after reset", r_rd, 0);
        chk("R1 pready", 32'(r_rdy), 1);
        apb(1'b0, 8'h18, 0); chk("R10 ctl control after reset", r_rd, 0);
        apb(1'b0, 8'h04, 0); chk("R10 top prefetch after reset", r_rd, 0);
        chk("R8 no error without fail-on-error", 32'(r_err), 0);

        // Data write with no committed index is dropped
        cnt0 = top_wr_cnt;
        apb(1'b1, 8'h04, 32'hDEAD_BEEF);
        chk("R8 dropped write strobe count", 32'(top_wr_cnt - cnt0), 0);
        apb(1'b1, 8'h08, 32'hFFFF_FFFF);
        apb(1'b0, 8'h08, 0); chk("R7 control readback bit 15 only", r_rd, 32'h0000_8000);
        apb(1'b1, 8'h04, 32'h1);
        chk("R8 error with fail-on-error", 32'(r_err), 1);
        chk("R8 still dropped", 32'(top_wr_cnt - cnt0), 0);

        // R9 undefined offsets
        apb(1'b0, 8'h0C, 0); chk("R9 undefined reads zero", r_rd, 0);
        chk("R9 no error with one window only", 32'(r_err), 0);
        apb(1'b1, 8'h18, 32'h0000_8000);
        apb(1'b0, 8'h40, 0); chk("R9 error with both enabled", 32'(r_err), 1);
        chk("R9 far offset reads zero", r_rd, 0);
        apb(1'b0, 8'h1C, 0); chk("R9 error at 0x1C", 32'(r_err), 1);
        apb(1'b1, 8'h08, 32'h0); apb(1'b1, 8'h18, 32'h0);

        // R3 pending discarded by other access, mismatch replaces
        apb(1'b1, 8'h00, 32'h5);
        apb(1'b0, 8'h08, 0);
        apb(1'b1, 8'h00, 32'h5);
        apb(1'b0, 8'h00, 0); chk("R3 interrupted pair does not commit", r_rd, 0);
        apb(1'b1, 8'h00, 32'h6);
        apb(1'b1, 8'h00, 32'h7);
        apb(1'b0, 8'h00, 0); chk("R3 mismatch does not commit", r_rd, 0);
        apb(1'b1, 8'h00, 32'h7);
        apb(1'b1, 8'h00, 32'h7);
        apb(1'b0, 8'h00, 0); chk("R3 replaced value commits", r_rd, 7);
        apb(1'b1, 8'h00, 32'h6);
        apb(1'b1, 8'h00, 32'h7);
        apb(1'b1, 8'h00, 32'h7);
        chk("R3 replaced pending commits on next match", 32'(top_addr), 7);

        // Sweep both spaces; read return and prefetch reload share an access
        exp_pf[0] = 0; exp_pf[1] = 0;
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < 8; a++) begin
                logic [7:0] base;
                base = (w == 1) ? 8'h10 : 8'h00;
                m = (w == 1) ? 32'h0000_00FF : 32'hFFFF_FFFF;
                v = 32'hC0DE_0000 | (32'(a) << 8) | (32'(a) * 17) | (32'(w) << 31);
                apb(1'b1, base, 32'hA5C3_0000 | 32'(a));
                apb(1'b1, base, 32'hA5C3_0000 | 32'(a));
                apb(1'b0, base, 0); chk("R2 committed index low 16 bits", r_rd, 32'(a));
                chk("R2 index output", (w == 1) ? 32'(ctl_addr) : 32'(top_addr), 32'(a));
                cnt0 = (w == 1) ? ctl_wr_cnt : top_wr_cnt;
                apb(1'b1, base + 8'h4, v);
                chk("R5 single write strobe",
                    32'(((w == 1) ? ctl_wr_cnt : top_wr_cnt) - cnt0), 1);
                chk("R5 no error on legal write", 32'(r_err), 0);
                apb(1'b0, base + 8'h4, 0); chk("R4 first read is stale", r_rd, exp_pf[w]);
                exp_pf[w] = v & m;
                apb(1'b0, base + 8'h4, 0); chk("R6 second read masked value", r_rd, v & m);
            end
        end

        // R10 reset clears everything
        @(negedge clk); rst = 1'b1;
        apb(1'b1, 8'h08, 32'h8000);
        repeat (2) @(negedge clk); rst = 1'b0;
        apb(1'b0, 8'h10, 0); chk("R10 ctl index cleared", r_rd, 0);
        apb(1'b0, 8'h08, 0); chk("R10 top control cleared", r_rd, 0);
        apb(1'b0, 8'h14, 0); chk("R10 ctl prefetch cleared", r_rd, 0);
        chk("R10 no error after reset", 32'(r_err), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule